// File: doc/BRIEF.md
# HDLC Transmit Byte Queue with CRC Append

This block sits between a processor's byte-write port and a bit-level HDLC transmitter. The processor writes bytes into a queue, and each byte carries a marker bit that flags it as the last byte of a frame. The transmitter pulls bytes over a byte-wide ready/valid stream. After a marked byte, the block either appends the two bytes of a frame check sequence or leaves them out, depending on a control input. It also reports queue occupancy, a low-water mark, a soft flush that clears itself, a transmit underrun and an end-of-frame pulse.

A separate down-counter counts the data bytes handed to the transmitter. Software loads it with a programmed value. When it runs out, it either stops at zero or reloads from the programmed value, under a cycle-enable input. Flag insertion, zero-bit stuffing and serialization happen downstream of this block.

Top module: `hdlc_txq`

## Requirements
- R1: After reset, the queue is empty: `fifo_empty`=1, `fifo_count`=0, `fifo_low`=1, `fifo_full`=0, `tx_valid`=0, `flush_active`=0 and `tx_underrun`=0.
- R2: Accepted bytes come out in write order. `fifo_count` follows the occupancy and `fifo_full` is set at DEPTH entries. A write to a full queue is ignored, and the ignored byte never appears on the stream.
- R3: `fifo_low` is 1 exactly when the occupancy is LOW_MARK or fewer (4 by default).
- R4: A one-cycle `flush_req` pulse empties the queue as of the next cycle: `fifo_empty`=1 and `fifo_count`=0. It also sets `flush_active`. The next accepted write clears `flush_active`, and that byte becomes the next byte offered.
- R5: If `crc_inhibit`=0 when a marked byte is handed off, two bytes follow it. These are the ones-complement of a CRC-16 (reflected polynomial 0x8408, i.e. x^16+x^12+x^5+1, preset 0xFFFF, bytes processed LSB first) taken over the frame's data bytes. The low byte is sent first. The second CRC byte carries `tx_last`=1. For the data bytes "123456789", the appended bytes are 0x6E then 0x90.
- R6: If `crc_inhibit`=1 when a marked byte is handed off, that byte carries `tx_last`=1 and no CRC bytes follow.
- R7: `tx_eop` pulses high for one cycle, in the cycle after the last byte of a frame is handed off.
- R8: `bc_load` loads `bc_value` and the reload register from `bc_load_val`. Each data byte handed off (CRC bytes excluded) decrements a nonzero `bc_value`. The step from 1 raises `bc_expire` for one cycle. With `cycle_en`=0, the count then stays at 0.
- R9: With `cycle_en`=1, the step from 1 reloads `bc_value` from the programmed value instead of going to 0.
- R10: If the transmitter is ready mid-frame (after an unmarked byte has been handed off) and the queue is empty, `tx_underrun` pulses for one cycle. The frame is then abandoned, and the next frame starts with a fresh CRC.
- R11: While `tx_valid`=1 and `tx_ready`=0, the offered byte and `tx_valid` are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Processor write strobe |
| wr_data | input | 8 | Byte to queue |
| wr_eop | input | 1 | Marks the byte as the last byte of its frame |
| flush_req | input | 1 | Soft flush pulse |
| crc_inhibit | input | 1 | Suppress CRC after the marked byte |
| cycle_en | input | 1 | Byte counter reloads on expiry |
| bc_load | input | 1 | Load the byte counter |
| bc_load_val | input | 8 | Programmed byte count |
| tx_ready | input | 1 | Transmitter accepts a byte |
| tx_valid | output | 1 | Byte offered |
| tx_data | output | 8 | Offered byte |
| tx_last | output | 1 | Offered byte ends the frame |
| tx_eop | output | 1 | End-of-frame pulse |
| tx_underrun | output | 1 | Underrun pulse |
| fifo_empty | output | 1 | Queue empty |
| fifo_full | output | 1 | Queue full |
| fifo_low | output | 1 | Occupancy at or under the low mark |
| fifo_count | output | 5 | Occupancy |
| flush_active | output | 1 | Flush pending until the next write |
| bc_value | output | 8 | Current byte count |
| bc_expire | output | 1 | Byte count expired |

## Verification
The bench builds the block with its defaults: a depth of 16, a low mark of 4 and an 8-bit byte counter. At that depth a directed test can fill the queue, push one byte past full, and walk `fifo_low` across its threshold byte by byte. The 8-bit counter lets short frames drive both the stop-at-zero case and two back-to-back reloads. The CRC is checked against the well-known nine-digit check string, which shows the bit order, the preset, the complement and the byte order all at once.

// File: rtl/hdlc_txq_pkg.sv
// Shared types and the frame check sequence update for the transmit queue.
// Assumes the reflected CRC-16 convention: data enters LSB first.
package hdlc_txq_pkg;

    typedef enum logic [1:0] {
        PH_DATA   = 2'd0,
        PH_FCS_LO = 2'd1,
        PH_FCS_HI = 2'd2
    } tx_phase_t;

    localparam logic [15:0] FCS_PRESET = 16'hFFFF;
    localparam logic [15:0] FCS_POLY_R = 16'h8408;

    // Fold one byte into the running check value, least significant bit first.
    function automatic logic [15:0] fcs_step(input logic [15:0] acc, input logic [7:0] b);
        logic [15:0] r;
        r = acc;
        for (int i = 0; i < 8; i++) begin
            if (r[0] ^ b[i]) r = (r >> 1) ^ FCS_POLY_R;
            else             r = r >> 1;
        end
        return r;
    endfunction

endpackage

// File: rtl/txq_store.sv
// Circular byte store with a frame marker bit on each entry.
// Assumes the caller never asserts wr_en when full or rd_en when empty.
// A flush moves the read pointer onto the write pointer; stored words are left alone.
module txq_store #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [DW:0]      wr_word,
    input  logic             rd_en,
    input  logic             flush,
    output logic [DW:0]      rd_word,
    output logic [CNT_W-1:0] count
);
    logic [DW:0]      mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    // Storage array write; contents are never reset.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_ptr] <= wr_word;
    end

    // Pointer and occupancy bookkeeping, with flush taking precedence over a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (wr_en) wr_ptr <= bump(wr_ptr);
            if (flush) begin
                rd_ptr <= wr_ptr;
                count  <= wr_en ? CNT_W'(1) : '0;
            end else begin
                if (rd_en) rd_ptr <= bump(rd_ptr);
                count <= count + CNT_W'(wr_en) - CNT_W'(rd_en);
            end
        end
    end

    // Head of the queue, read without a register stage.
    assign rd_word = mem[rd_ptr];

endmodule

// File: rtl/txq_bytecnt.sv
// Down-counter of data bytes sent, with optional auto-reload on expiry.
// Assumes tick is high for exactly one cycle per data byte handed off.
module txq_bytecnt #(
    parameter int BC_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [BC_W-1:0] load_val,
    input  logic            cycle_en,
    input  logic            tick,
    output logic [BC_W-1:0] value,
    output logic            expire
);
    logic [BC_W-1:0] reload_q;

    // Load, decrement and expiry handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= '0;
            value    <= '0;
            expire   <= 1'b0;
        end else begin
            expire <= 1'b0;
            if (load) begin
                reload_q <= load_val;
                value    <= load_val;
            end else if (tick && value != '0) begin
                if (value == BC_W'(1)) begin
                    expire <= 1'b1;
                    value  <= cycle_en ? reload_q : '0;
                end else begin
                    value <= value - BC_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/txq_fcs.sv
// Frame check accumulator: folds in data bytes, resets between frames,
// and presents the complemented result split into low and high bytes.
module txq_fcs (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       add,
    input  logic [7:0] din,
    input  logic       restart,
    output logic [7:0] fcs_lo,
    output logic [7:0] fcs_hi
);
    import hdlc_txq_pkg::*;

    logic [15:0] acc;

    // Running check value; restart wins over add.
    always_ff @(posedge clk) begin
        if (!rst_n)       acc <= FCS_PRESET;
        else if (restart) acc <= FCS_PRESET;
        else if (add)     acc <= fcs_step(acc, din);
    end

    // Complemented result, low byte sent first.
    assign fcs_lo = ~acc[7:0];
    assign fcs_hi = ~acc[15:8];

endmodule

// File: rtl/hdlc_txq.sv
// Transmit byte queue for an HDLC framer: accepts marked bytes from a
// processor, offers them on a ready/valid stream, appends or suppresses
// the check sequence per frame, and tracks a reloadable byte count.
// Assumes the downstream framer adds flags and performs bit stuffing.
module hdlc_txq #(
    parameter int DEPTH    = 16,
    parameter int LOW_MARK = 4,
    parameter int BC_W     = 8,
    localparam int CNT_W   = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic             wr_eop,
    input  logic             flush_req,
    input  logic             crc_inhibit,
    input  logic             cycle_en,
    input  logic             bc_load,
    input  logic [BC_W-1:0]  bc_load_val,
    input  logic             tx_ready,
    output logic             tx_valid,
    output logic [7:0]       tx_data,
    output logic             tx_last,
    output logic             tx_eop,
    output logic             tx_underrun,
    output logic             fifo_empty,
    output logic             fifo_full,
    output logic             fifo_low,
    output logic [CNT_W-1:0] fifo_count,
    output logic             flush_active,
    output logic [BC_W-1:0]  bc_value,
    output logic             bc_expire
);
    import hdlc_txq_pkg::*;

    tx_phase_t  phase;
    logic       in_frame;
    logic [8:0] head;
    logic       wr_ok;
    logic       take;
    logic       data_take;
    logic       frame_done;
    logic       starve;
    logic       fcs_restart;
    logic [7:0] fcs_lo;
    logic [7:0] fcs_hi;

    // Status decode from the registered occupancy.
    assign fifo_empty = (fifo_count == '0);
    assign fifo_full  = (fifo_count == CNT_W'(DEPTH));
    assign fifo_low   = (fifo_count <= CNT_W'(LOW_MARK));
    assign wr_ok      = wr_en && !fifo_full;

    txq_store #(.DEPTH(DEPTH), .DW(8)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_ok),
        .wr_word ({wr_eop, wr_data}),
        .rd_en   (data_take && !flush_req),
        .flush   (flush_req),
        .rd_word (head),
        .count   (fifo_count)
    );

    // Stream mux: queue head during data, check bytes afterwards.
    always_comb begin
        tx_valid = 1'b0;
        tx_data  = head[7:0];
        tx_last  = 1'b0;
        unique case (phase)
            PH_DATA: begin
                tx_valid = !fifo_empty;
                tx_last  = head[8] && crc_inhibit;
            end
            PH_FCS_LO: begin
                tx_valid = 1'b1;
                tx_data  = fcs_lo;
            end
            PH_FCS_HI: begin
                tx_valid = 1'b1;
                tx_data  = fcs_hi;
                tx_last  = 1'b1;
            end
            default: ;
        endcase
    end

    assign take        = tx_valid && tx_ready;
    assign data_take   = take && (phase == PH_DATA);
    assign frame_done  = take && tx_last;
    assign starve      = (phase == PH_DATA) && in_frame && fifo_empty && tx_ready;
    assign fcs_restart = frame_done || starve;

    txq_fcs u_fcs (
        .clk     (clk),
        .rst_n   (rst_n),
        .add     (data_take),
        .din     (head[7:0]),
        .restart (fcs_restart),
        .fcs_lo  (fcs_lo),
        .fcs_hi  (fcs_hi)
    );

    txq_bytecnt #(.BC_W(BC_W)) u_bcnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (bc_load),
        .load_val (bc_load_val),
        .cycle_en (cycle_en),
        .tick     (data_take),
        .value    (bc_value),
        .expire   (bc_expire)
    );

    // Frame phase sequencing on each handoff and on starvation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_DATA;
            in_frame <= 1'b0;
        end else if (starve) begin
            in_frame <= 1'b0;
        end else if (take) begin
            unique case (phase)
                PH_DATA: begin
                    if (!head[8])         in_frame <= 1'b1;
                    else if (crc_inhibit) in_frame <= 1'b0;
                    else begin
                        in_frame <= 1'b1;
                        phase    <= PH_FCS_LO;
                    end
                end
                PH_FCS_LO: phase <= PH_FCS_HI;
                PH_FCS_HI: begin
                    phase    <= PH_DATA;
                    in_frame <= 1'b0;
                end
                default: phase <= PH_DATA;
            endcase
        end
    end

    // One-cycle event flags for end of frame and underrun.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_eop      <= 1'b0;
            tx_underrun <= 1'b0;
        end else begin
            tx_eop      <= frame_done;
            tx_underrun <= starve;
        end
    end

    // Self-clearing flush flag: set by the pulse, cleared by the next accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n)          flush_active <= 1'b0;
        else if (wr_ok)      flush_active <= 1'b0;
        else if (flush_req)  flush_active <= 1'b1;
    end

endmodule

// File: rtl/hdlc_txq_chk.sv
// Property checker for the transmit queue, attached by bind.
module hdlc_txq_chk #(
    parameter int DEPTH    = 16,
    parameter int CNT_W    = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             flush_req,
    input logic             tx_ready,
    input logic             tx_valid,
    input logic [7:0]       tx_data,
    input logic             tx_last,
    input logic             tx_eop,
    input logic             tx_underrun,
    input logic             fifo_empty,
    input logic             fifo_low,
    input logic [CNT_W-1:0] fifo_count,
    input logic             bc_expire
);
    // R2: occupancy never exceeds the depth.
    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_count <= CNT_W'(DEPTH));

    // R3: an empty queue is always under the low mark.
    assert_empty_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_empty |-> fifo_low);

    // R4: a flush without a write empties the queue next cycle.
    assert_flush_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_req && !wr_en) |=> fifo_empty);

    // R7: the end-of-frame pulse follows a final handoff.
    assert_eop_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && tx_last) |=> tx_eop);

    // R8: expiry only follows a handoff.
    assert_expire_on_take_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bc_expire |-> $past(tx_valid && tx_ready));

    // R10: underrun only after an empty queue.
    assert_underrun_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_underrun |-> $past(fifo_empty));

    // R11: an offered byte is held under backpressure.
    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !flush_req) |=> (tx_valid && $stable(tx_data)));

endmodule

bind hdlc_txq hdlc_txq_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .flush_req   (flush_req),
    .tx_ready    (tx_ready),
    .tx_valid    (tx_valid),
    .tx_data     (tx_data),
    .tx_last     (tx_last),
    .tx_eop      (tx_eop),
    .tx_underrun (tx_underrun),
    .fifo_empty  (fifo_empty),
    .fifo_low    (fifo_low),
    .fifo_count  (fifo_count),
    .bc_expire   (bc_expire)
);

// File: tb/hdlc_txq_bench.sv
// Directed bench for the transmit queue; inputs change on falling edges.
module hdlc_txq_bench;
    localparam int DEPTH = 16;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0, wr_eop = 1'b0, flush_req = 1'b0, crc_inhibit = 1'b1;
    logic cycle_en = 1'b0, bc_load = 1'b0, tx_ready = 1'b0;
    logic [7:0] wr_data = '0, bc_load_val = '0;
    logic tx_valid, tx_last, tx_eop, tx_underrun, fifo_empty, fifo_full, fifo_low;
    logic flush_active, bc_expire;
    logic [7:0] tx_data, bc_value;
    logic [CNT_W-1:0] fifo_count;

    int checks = 0;
    int errors = 0;
    int expire_seen = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    hdlc_txq u_hdlc_txq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_eop(wr_eop),
        .flush_req(flush_req), .crc_inhibit(crc_inhibit), .cycle_en(cycle_en),
        .bc_load(bc_load), .bc_load_val(bc_load_val), .tx_ready(tx_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_eop(tx_eop),
        .tx_underrun(tx_underrun), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
        .fifo_low(fifo_low), .fifo_count(fifo_count), .flush_active(flush_active),
        .bc_value(bc_value), .bc_expire(bc_expire)
    );

    always @(negedge clk) if (rst_n && bc_expire) expire_seen++;

    // Reference check value: reflected CRC-16, preset all ones.
    function automatic logic [15:0] ref_crc(input logic [7:0] bytes[], input int n);
        logic [15:0] c = 16'hFFFF;
        for (int k = 0; k < n; k++) begin
            c = c ^ {8'h00, bytes[k]};
            for (int j = 0; j < 8; j++) c = c[0] ? ((c >> 1) ^ 16'h8408) : (c >> 1);
        end
        return ~c;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] d, input logic eop);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d; wr_eop = eop;
        @(negedge clk);
        wr_en = 1'b0; wr_eop = 1'b0;
    endtask

    // Check the offered byte at this falling edge; it is taken on the next rise.
    task automatic pull(input logic [7:0] d, input logic last, input string req);
        chk(tx_valid == 1'b1, req, tx_valid, 1);
        chk(tx_data == d, req, tx_data, d);
        chk(tx_last == last, req, tx_last, last);
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk(fifo_empty == 1 && fifo_count == 0, "R1", fifo_count, 0);
        chk(fifo_low == 1 && fifo_full == 0, "R1", {fifo_low, fifo_full}, 2'b10);
        chk(tx_valid == 0 && flush_active == 0 && tx_underrun == 0, "R1", tx_valid, 0);
    endtask

    task automatic t_fill();
        tx_ready = 1'b0; crc_inhibit = 1'b1;
        for (int i = 0; i < DEPTH; i++) begin
            push(8'h40 + 8'(i), i == DEPTH - 1);
            if (i == 3) chk(fifo_low == 1, "R3", fifo_low, 1);
            if (i == 4) chk(fifo_low == 0, "R3", fifo_low, 0);
        end
        chk(fifo_full == 1 && fifo_count == CNT_W'(DEPTH), "R2", fifo_count, DEPTH);
        push(8'hEE, 1'b1);
        chk(fifo_count == CNT_W'(DEPTH), "R2", fifo_count, DEPTH);
        tx_ready = 1'b1;
        for (int i = 0; i < DEPTH; i++) pull(8'h40 + 8'(i), i == DEPTH - 1, "R2");
        chk(tx_eop == 1, "R7", tx_eop, 1);
        chk(tx_valid == 0 && fifo_empty == 1, "R6", tx_valid, 0);
        @(negedge clk);
        chk(tx_eop == 0, "R7", tx_eop, 0);
    endtask

    task automatic t_crc();
        logic [7:0] s[] = '{8'h31,8'h32,8'h33,8'h34,8'h35,8'h36,8'h37,8'h38,8'h39};
        logic [15:0] f;
        f = ref_crc(s, 9);
        chk(f == 16'h906E, "R5", f, 16'h906E);
        tx_ready = 1'b0; crc_inhibit = 1'b0;
        for (int i = 0; i < 9; i++) push(s[i], i == 8);
        chk(tx_valid == 1 && tx_data == 8'h31, "R11", tx_data, 8'h31);
        @(negedge clk);
        chk(tx_valid == 1 && tx_data == 8'h31, "R11", tx_data, 8'h31);
        tx_ready = 1'b1;
        for (int i = 0; i < 9; i++) pull(s[i], 1'b0, "R5");
        pull(f[7:0], 1'b0, "R5");
        pull(f[15:8], 1'b1, "R5");
        chk(tx_eop == 1 && tx_valid == 0, "R7", tx_eop, 1);
    endtask

    task automatic t_flush();
        tx_ready = 1'b0; crc_inhibit = 1'b1;
        push(8'h01, 0); push(8'h02, 0); push(8'h03, 1);
        @(negedge clk); flush_req = 1'b1;
        @(negedge clk); flush_req = 1'b0;
        chk(fifo_empty == 1 && fifo_count == 0, "R4", fifo_count, 0);
        chk(flush_active == 1 && tx_valid == 0, "R4", flush_active, 1);
        push(8'h5A, 1);
        chk(flush_active == 0 && fifo_count == 1, "R4", fifo_count, 1);
        tx_ready = 1'b1;
        pull(8'h5A, 1'b1, "R4");
    endtask

    task automatic t_underrun();
        int hits = 0;
        logic [7:0] one[] = '{8'h7E};
        logic [15:0] f;
        crc_inhibit = 1'b0; tx_ready = 1'b1;
        push(8'h11, 0);
        pull(8'h11, 1'b0, "R10");
        for (int i = 0; i < 5; i++) begin
            if (tx_underrun) hits++;
            @(negedge clk);
        end
        chk(hits == 1, "R10", hits, 1);
        chk(tx_valid == 0, "R10", tx_valid, 0);
        f = ref_crc(one, 1);
        push(8'h7E, 1);
        pull(8'h7E, 1'b0, "R10");
        pull(f[7:0], 1'b0, "R10");
        pull(f[15:8], 1'b1, "R10");
    endtask

    task automatic run_bytes(input int n);
        tx_ready = 1'b0;
        for (int i = 0; i < n; i++) push(8'(i), i == n - 1);
        tx_ready = 1'b1;
        for (int i = 0; i < n; i++) pull(8'(i), i == n - 1, "R8");
        @(negedge clk);
    endtask

    task automatic t_count();
        crc_inhibit = 1'b1; cycle_en = 1'b0;
        @(negedge clk); bc_load = 1'b1; bc_load_val = 8'd3;
        @(negedge clk); bc_load = 1'b0;
        chk(bc_value == 3, "R8", bc_value, 3);
        expire_seen = 0;
        run_bytes(4);
        chk(bc_value == 0, "R8", bc_value, 0);
        chk(expire_seen == 1, "R8", expire_seen, 1);
        crc_inhibit = 1'b0;
        @(negedge clk); bc_load = 1'b1; bc_load_val = 8'd5;
        @(negedge clk); bc_load = 1'b0;
        push(8'hA1, 1);
        pull(8'hA1, 1'b0, "R8");
        @(negedge clk); @(negedge clk);
        chk(bc_value == 4, "R8", bc_value, 4);
        crc_inhibit = 1'b1; cycle_en = 1'b1;
        @(negedge clk); bc_load = 1'b1; bc_load_val = 8'd2;
        @(negedge clk); bc_load = 1'b0;
        expire_seen = 0;
        run_bytes(5);
        chk(bc_value == 1, "R9", bc_value, 1);
        chk(expire_seen == 2, "R9", expire_seen, 2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fill();
        t_crc();
        t_flush();
        t_underrun();
        t_count();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule